// File: doc/BRIEF.md
# Strobed Serial Command Interface for a Display Controller

This block is the host-facing slave port of a vacuum fluorescent display controller. A host drives a strobe line, a serial clock and a data-in line. The block returns read data on a single open-drain line. All three inputs are asynchronous to the system clock. They pass through synchronisers, and the block then detects serial clock edges by oversampling them. Each strobe-low window is one transaction. The first byte of the window is a command. Every later byte is data, and its destination depends on the most recent data-setting command.

Commands choose the digit/segment mode, the dimming code and the display enable. They also set the data target and addressing style, and the display memory address. Data bytes go to the display RAM write port or to the LED port. In a read transaction, key-matrix bytes or switch bytes are shifted out instead. The stored values are driven to the scan, dimming and LED driver blocks.

Top module: `vfd_serial_ctrl`

## Requirements
- R1: Serial data is sampled on rising serial clock edges, least significant bit first. The first byte after the strobe falls is a command, and its bits 7:6 give the class: 00 mode, 01 data setting, 10 display control, 11 address.
- R2: While the strobe is high, serial clock edges have no effect. Raising the strobe part way through a byte discards that partial byte, and the next transaction starts with a fresh bit count.
- R3: A mode command stores bits 3:0 in `mode_o`, stored as 0000 whenever bit 3 is 0. If the stored value changes, `disp_on_o` is cleared. If the value is the same, nothing changes. The reset value is 1111.
- R4: A display control command sets `disp_on_o` from bit 3 and `dim_o` from bits 2:0. Both reset to 0.
- R5: A data-setting command stores bits 1:0 as the target (00 display RAM write, 01 LED write, 10 key read, 11 switch read), bit 2 as fixed addressing (1) or auto-increment (0), and bit 3 as `test_mode_o`. All of these reset to 0.
- R6: An address command loads bits 5:0 into the write address. The address resets to 0.
- R7: When the target is 00 and the address is below 30h, each complete data byte produces one `ram_we_o` pulse with the current address and the byte. After the byte, the address goes up by one in auto-increment mode and stays the same in fixed mode.
- R8: While the address is 30h or above, data bytes cause no write and no address change until a new address command arrives.
- R9: When the target is 01, data bits 4:0 drive `led_n_o[4:0]` (active low, bit 0 is the first LED). Bits 7:5 are ignored. `led_n_o` resets to 11111.
- R10: After a switch-read command, each read byte is {0000, sw_i[3:0]}, sent least significant bit first. A new bit appears at each falling serial clock edge, and bit 0 appears at the first falling edge after the command.
- R11: After a key-read command, read byte k is `key_i[8k+7:8k]` for k = 0 to 5, and the sequence then wraps back to byte 0.
- R12: `dout_oe_o` (drive low) is high only while a read is active and the current bit is 0. It is released once the strobe goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stb_i | input | 1 | Transaction strobe, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous, idles high |
| din_i | input | 1 | Serial data in |
| sw_i | input | 4 | General purpose switch inputs |
| key_i | input | 48 | Key matrix bytes from the scan block |
| dout_o | output | 1 | Current serial output bit (1 = released) |
| dout_oe_o | output | 1 | Open-drain pull-low enable |
| ram_we_o | output | 1 | Display RAM write strobe |
| ram_addr_o | output | 6 | Display RAM write address |
| ram_wdata_o | output | 8 | Display RAM write data |
| led_n_o | output | 5 | LED port, active low |
| mode_o | output | 4 | Digit/segment mode code |
| disp_on_o | output | 1 | Display enable |
| dim_o | output | 3 | Dimming code |
| test_mode_o | output | 1 | Test mode flag |

## Verification
A serial edge takes two synchroniser stages and one edge-detect register to reach the logic. Register updates and the RAM write pulse therefore land four system clocks after the rising edge that completes a byte, and a new DOUT bit lands three clocks after a falling edge. The bench holds each serial level for eight system clocks. It samples DOUT just before the next rising edge. It reads registers only after the strobe has risen and a further twelve clocks have passed, so every sample falls well after its result is due. Writes are captured on the opposite clock edge and compared, address by address, with a model of the auto-increment and fixed addressing.

// File: rtl/vfd_ctrl_pkg.sv
package vfd_ctrl_pkg;
  typedef enum logic [1:0] {
    CLS_MODE = 2'b00,
    CLS_DSET = 2'b01,
    CLS_DCTL = 2'b10,
    CLS_ADDR = 2'b11
  } cmd_cls_e;

  typedef enum logic [1:0] {
    TGT_RAM = 2'b00,
    TGT_LED = 2'b01,
    TGT_KEY = 2'b10,
    TGT_SW  = 2'b11
  } tgt_e;
endpackage

// File: rtl/vfd_sync.sv
module vfd_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff <= {STAGES{RST_VAL[g]}};
      else         ff <= {ff[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = ff[STAGES-1];
  end
endmodule

// File: rtl/vfd_serial_rx.sv
module vfd_serial_rx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic              sclk_fall_o,
  output logic              byte_vld_o,
  output logic              is_cmd_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic              sclk_q;
  logic              first_q;
  logic              vld_q;
  logic              is_cmd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] byte_q;
  logic              rise;

  assign rise        =  sclk_i & ~sclk_q & ~stb_i;
  assign sclk_fall_o = ~sclk_i &  sclk_q & ~stb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q   <= 1'b1;
      first_q  <= 1'b1;
      vld_q    <= 1'b0;
      is_cmd_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      byte_q   <= '0;
    end else begin
      sclk_q <= sclk_i;
      vld_q  <= 1'b0;
      if (stb_i) begin
        cnt_q   <= '0;
        first_q <= 1'b1;
      end else if (rise) begin
        sh_q <= {din_i, sh_q[BYTE_W-1:1]};
        if (cnt_q == CNT_W'(BYTE_W-1)) begin
          cnt_q    <= '0;
          vld_q    <= 1'b1;
          byte_q   <= {din_i, sh_q[BYTE_W-1:1]};
          is_cmd_q <= first_q;
          first_q  <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign byte_vld_o = vld_q;
  assign is_cmd_o   = is_cmd_q;
  assign byte_o     = byte_q;

  // R2: strobe high blocks byte completion and clears the bit count
  a_r2_stb_blocks_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |=> !byte_vld_o);
  a_r2_stb_clears_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |=> (cnt_q == '0));
  // R1: only one command byte per strobe window
  a_r1_single_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_o && is_cmd_o) |-> !first_q);
endmodule

// File: rtl/vfd_cmd_regs.sv
module vfd_cmd_regs
  import vfd_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int RAM_DEPTH = 48,
  parameter int LED_W     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic              is_cmd_i,
  input  logic [7:0]        byte_i,
  output logic              rd_start_o,
  output logic              rd_key_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [7:0]        ram_wdata_o,
  output logic [LED_W-1:0]  led_n_o,
  output logic [3:0]        mode_o,
  output logic              disp_on_o,
  output logic [2:0]        dim_o,
  output logic              test_mode_o
);
  localparam logic [ADDR_W-1:0] ADDR_LIM = ADDR_W'(RAM_DEPTH);

  cmd_cls_e          cls;
  tgt_e              tgt_q;
  logic              fixed_q;
  logic              test_q;
  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        mode_q;
  logic [3:0]        nmode;
  logic              disp_on_q;
  logic [2:0]        dim_q;
  logic [LED_W-1:0]  led_q;
  logic              we_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [7:0]        wdata_q;
  logic              addr_ok;

  assign cls     = cmd_cls_e'(byte_i[7:6]);
  assign nmode   = byte_i[3] ? byte_i[3:0] : 4'b0000;
  assign addr_ok = addr_q < ADDR_LIM;

  assign rd_start_o = byte_vld_i && is_cmd_i && (cls == CLS_DSET) && byte_i[1];
  assign rd_key_o   = ~byte_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q     <= TGT_RAM;
      fixed_q   <= 1'b0;
      test_q    <= 1'b0;
      addr_q    <= '0;
      mode_q    <= 4'b1111;
      disp_on_q <= 1'b0;
      dim_q     <= '0;
      led_q     <= '1;
      we_q      <= 1'b0;
      waddr_q   <= '0;
      wdata_q   <= '0;
    end else begin
      we_q <= 1'b0;
      if (byte_vld_i) begin
        if (is_cmd_i) begin
          unique case (cls)
            CLS_MODE: if (nmode != mode_q) begin
              mode_q    <= nmode;
              disp_on_q <= 1'b0;
            end
            CLS_DSET: begin
              tgt_q   <= tgt_e'(byte_i[1:0]);
              fixed_q <= byte_i[2];
              test_q  <= byte_i[3];
            end
            CLS_DCTL: begin
              disp_on_q <= byte_i[3];
              dim_q     <= byte_i[2:0];
            end
            CLS_ADDR: addr_q <= byte_i[ADDR_W-1:0];
          endcase
        end else begin
          case (tgt_q)
            TGT_RAM: if (addr_ok) begin
              we_q    <= 1'b1;
              waddr_q <= addr_q;
              wdata_q <= byte_i;
              if (!fixed_q) addr_q <= addr_q + 1'b1;
            end
            TGT_LED: led_q <= byte_i[LED_W-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  assign ram_we_o    = we_q;
  assign ram_addr_o  = waddr_q;
  assign ram_wdata_o = wdata_q;
  assign led_n_o     = led_q;
  assign mode_o      = mode_q;
  assign disp_on_o   = disp_on_q;
  assign dim_o       = dim_q;
  assign test_mode_o = test_q;

  // R7: address stepping after each write
  a_r7_auto_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q && !fixed_q) |-> (addr_q == waddr_q + 1'b1));
  a_r7_fixed_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q && fixed_q) |-> (addr_q == waddr_q));
  // R8: no write outside the RAM
  a_r8_write_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_addr_o < ADDR_LIM));
  a_r8_addr_on_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(addr_q) |-> $past(byte_vld_i));
  // R3: a mode change leaves the display off
  a_r3_mode_blanks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_q) |-> !disp_on_q);
  // R9: LED port only moves on an LED data byte
  a_r9_led_on_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(led_q) |-> $past(byte_vld_i && !is_cmd_i && tgt_q == TGT_LED));
endmodule

// File: rtl/vfd_read_tx.sv
module vfd_read_tx #(
  parameter int KEY_BYTES = 6,
  parameter int SW_W      = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   stb_i,
  input  logic                   fall_i,
  input  logic                   rd_start_i,
  input  logic                   rd_key_i,
  input  logic [KEY_BYTES*8-1:0] key_i,
  input  logic [SW_W-1:0]        sw_i,
  output logic                   dout_o,
  output logic                   dout_oe_o
);
  localparam int IDX_W = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1;

  logic             active_q;
  logic             key_sel_q;
  logic [2:0]       bit_q;
  logic [IDX_W-1:0] idx_q;
  logic             dout_q;
  logic [7:0]       cur_byte;

  assign cur_byte = key_sel_q ? key_i[int'(idx_q)*8 +: 8]
                              : {{(8-SW_W){1'b0}}, sw_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      key_sel_q <= 1'b0;
      bit_q     <= '0;
      idx_q     <= '0;
      dout_q    <= 1'b1;
    end else if (stb_i) begin
      active_q <= 1'b0;
      bit_q    <= '0;
      idx_q    <= '0;
      dout_q   <= 1'b1;
    end else if (rd_start_i) begin
      active_q  <= 1'b1;
      key_sel_q <= rd_key_i;
      bit_q     <= '0;
      idx_q     <= '0;
    end else if (active_q && fall_i) begin
      dout_q <= cur_byte[bit_q];
      bit_q  <= bit_q + 1'b1;
      if (bit_q == 3'd7)
        idx_q <= (idx_q == IDX_W'(KEY_BYTES-1)) ? '0 : idx_q + 1'b1;
    end
  end

  assign dout_o    = dout_q;
  assign dout_oe_o = active_q & ~dout_q;

  // R12: line released once strobe is high
  a_r12_release_on_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |=> !dout_oe_o);
  // R10: output bit only moves on a falling serial edge
  a_r10_dout_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall_i && !stb_i) |=> $stable(dout_o));
endmodule

// File: rtl/vfd_serial_ctrl.sv
module vfd_serial_ctrl #(
  parameter int ADDR_W      = 6,
  parameter int RAM_DEPTH   = 48,
  parameter int LED_W       = 5,
  parameter int KEY_BYTES   = 6,
  parameter int SW_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   stb_i,
  input  logic                   sclk_i,
  input  logic                   din_i,
  input  logic [SW_W-1:0]        sw_i,
  input  logic [KEY_BYTES*8-1:0] key_i,
  output logic                   dout_o,
  output logic                   dout_oe_o,
  output logic                   ram_we_o,
  output logic [ADDR_W-1:0]      ram_addr_o,
  output logic [7:0]             ram_wdata_o,
  output logic [LED_W-1:0]       led_n_o,
  output logic [3:0]             mode_o,
  output logic                   disp_on_o,
  output logic [2:0]             dim_o,
  output logic                   test_mode_o
);
  logic [2:0]      ser_s;
  logic [SW_W-1:0] sw_s;
  logic            fall, byte_vld, is_cmd, rd_start, rd_key;
  logic [7:0]      rx_byte;

  // {din, sclk, stb}: line idles with strobe and clock high
  vfd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) i_ser_sync (
    .clk_i, .rst_ni, .d_i({din_i, sclk_i, stb_i}), .q_o(ser_s)
  );

  vfd_sync #(.W(SW_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_sw_sync (
    .clk_i, .rst_ni, .d_i(sw_i), .q_o(sw_s)
  );

  vfd_serial_rx #(.BYTE_W(8)) i_rx (
    .clk_i, .rst_ni,
    .stb_i(ser_s[0]), .sclk_i(ser_s[1]), .din_i(ser_s[2]),
    .sclk_fall_o(fall), .byte_vld_o(byte_vld), .is_cmd_o(is_cmd), .byte_o(rx_byte)
  );

  vfd_cmd_regs #(.ADDR_W(ADDR_W), .RAM_DEPTH(RAM_DEPTH), .LED_W(LED_W)) i_regs (
    .clk_i, .rst_ni,
    .byte_vld_i(byte_vld), .is_cmd_i(is_cmd), .byte_i(rx_byte),
    .rd_start_o(rd_start), .rd_key_o(rd_key),
    .ram_we_o, .ram_addr_o, .ram_wdata_o, .led_n_o,
    .mode_o, .disp_on_o, .dim_o, .test_mode_o
  );

  vfd_read_tx #(.KEY_BYTES(KEY_BYTES), .SW_W(SW_W)) i_tx (
    .clk_i, .rst_ni,
    .stb_i(ser_s[0]), .fall_i(fall), .rd_start_i(rd_start), .rd_key_i(rd_key),
    .key_i, .sw_i(sw_s), .dout_o, .dout_oe_o
  );
endmodule

// File: tb/test_vfd_serial_ctrl.sv
module test_vfd_serial_ctrl;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        stb_i = 1'b1, sclk_i = 1'b1, din_i = 1'b0;
  logic [3:0]  sw_i = '0;
  logic [47:0] key_i = '0;
  logic        dout_o, dout_oe_o, ram_we_o, disp_on_o, test_mode_o;
  logic [5:0]  ram_addr_o;
  logic [7:0]  ram_wdata_o;
  logic [4:0]  led_n_o;
  logic [3:0]  mode_o;
  logic [2:0]  dim_o;

  int checks = 0, errors = 0;
  int wr_cnt = 0, exp_wr = 0;
  logic [7:0] seen_mem [64];
  logic [7:0] exp_mem  [64];
  logic [7:0] txq [$];
  logic [7:0] rdq [$];

  always #2 clk = ~clk;

  vfd_serial_ctrl i_vfd_serial_ctrl (
    .clk_i(clk), .rst_ni, .stb_i, .sclk_i, .din_i, .sw_i, .key_i,
    .dout_o, .dout_oe_o, .ram_we_o, .ram_addr_o, .ram_wdata_o, .led_n_o,
    .mode_o, .disp_on_o, .dim_o, .test_mode_o
  );

  always @(negedge clk) begin
    if (rst_ni && ram_we_o) begin
      seen_mem[ram_addr_o] = ram_wdata_o;
      wr_cnt++;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic half_wait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic ser_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sclk_i = 1'b0; din_i = b[i]; half_wait();
      sclk_i = 1'b1; half_wait();
    end
  endtask

  task automatic xfer();
    stb_i = 1'b0; half_wait();
    foreach (txq[i]) ser_bits(txq[i], 8);
    stb_i = 1'b1;
    repeat (12) @(negedge clk);
    txq.delete();
  endtask

  task automatic cmd1(input logic [7:0] c);
    txq.push_back(c);
    xfer();
  endtask

  task automatic read_xfer(input logic [7:0] cmd, input int n);
    rdq.delete();
    stb_i = 1'b0; half_wait();
    ser_bits(cmd, 8);
    for (int j = 0; j < n; j++) begin
      logic [7:0] v;
      for (int i = 0; i < 8; i++) begin
        sclk_i = 1'b0; half_wait();
        v[i] = dout_oe_o ? 1'b0 : 1'b1;
        sclk_i = 1'b1; half_wait();
      end
      rdq.push_back(v);
    end
    stb_i = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  // R7 R8: write burst with model of addressing
  task automatic do_write(input logic [5:0] a0, input bit fixed, input int n);
    logic [5:0] a;
    int mism;
    cmd1(fixed ? 8'h44 : 8'h40);
    txq.push_back(8'hC0 | {2'b00, a0});
    a = a0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      txq.push_back(b);
      if (a < 6'd48) begin
        exp_mem[a] = b;
        exp_wr++;
        if (!fixed) a = a + 1'b1;
      end
    end
    xfer();
    mism = 0;
    for (int k = 0; k < 48; k++) if (seen_mem[k] !== exp_mem[k]) mism++;
    check("R7 ram contents", 64'(mism), 64'd0);
    check("R8 write count", 64'(wr_cnt), 64'(exp_wr));
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd7421);
    for (int k = 0; k < 64; k++) begin seen_mem[k] = '0; exp_mem[k] = '0; end
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    check("R9 reset led", 64'(led_n_o), 64'h1F);
    check("R3 reset mode", 64'(mode_o), 64'hF);
    check("R4 reset disp", 64'(disp_on_o), 64'd0);
    check("R4 reset dim", 64'(dim_o), 64'd0);
    check("R5 reset test", 64'(test_mode_o), 64'd0);
    check("R12 reset oe", 64'(dout_oe_o), 64'd0);

    // R4 / R1 display control class
    cmd1(8'h8F);
    check("R4 disp on", 64'(disp_on_o), 64'd1);
    check("R4 dim", 64'(dim_o), 64'd7);
    // R3 same mode: no blanking
    cmd1(8'h0F);
    check("R3 same mode keeps display", 64'(disp_on_o), 64'd1);
    cmd1(8'h0A);
    check("R3 new mode", 64'(mode_o), 64'hA);
    check("R3 new mode blanks", 64'(disp_on_o), 64'd0);
    cmd1(8'h8B);
    check("R4 dim 3", 64'(dim_o), 64'd3);
    cmd1(8'h03);
    check("R3 bit3 clear -> 0000", 64'(mode_o), 64'h0);
    check("R3 blank after 0000", 64'(disp_on_o), 64'd0);
    cmd1(8'h88);
    cmd1(8'h06);
    check("R3 equivalent mode ignored", 64'(disp_on_o), 64'd1);

    // R5 test mode bit
    cmd1(8'h4C);
    check("R5 test mode set", 64'(test_mode_o), 64'd1);
    cmd1(8'h40);
    check("R5 test mode clear", 64'(test_mode_o), 64'd0);

    // R6 R7 auto-increment, fixed, boundary, invalid
    do_write(6'h00, 1'b0, 5);
    do_write(6'h10, 1'b1, 3);
    do_write(6'h2E, 1'b0, 4);
    do_write(6'h35, 1'b0, 3);
    do_write(6'h30, 1'b1, 2);

    // R9 LED port, high bits ignored, LSB first
    txq.push_back(8'h41); txq.push_back(8'hE5); xfer();
    check("R9 led bits 4:0 only", 64'(led_n_o), 64'h05);

    // R2 clocks while strobe high are ignored
    for (int i = 0; i < 11; i++) begin
      sclk_i = 1'b0; din_i = 1'($urandom); half_wait();
      sclk_i = 1'b1; half_wait();
    end
    txq.push_back(8'h41); txq.push_back(8'h13); xfer();
    check("R2 clocks ignored with strobe high", 64'(led_n_o), 64'h13);
    // R2 abort mid-byte
    stb_i = 1'b0; half_wait();
    ser_bits(8'h41, 8);
    ser_bits(8'h00, 5);
    stb_i = 1'b1; repeat (12) @(negedge clk);
    check("R2 partial byte discarded", 64'(led_n_o), 64'h13);
    txq.push_back(8'h41); txq.push_back(8'h1C); xfer();
    check("R2 fresh count after abort", 64'(led_n_o), 64'h1C);

    // R10 switch read, R12 release
    for (int t = 0; t < 3; t++) begin
      logic [3:0] s;
      s = (t == 0) ? 4'hA : 4'($urandom);
      sw_i = s;
      repeat (6) @(negedge clk);
      read_xfer(8'h43, 2);
      check("R10 switch byte 0", 64'(rdq[0]), 64'({4'h0, s}));
      check("R10 switch byte 1", 64'(rdq[1]), 64'({4'h0, s}));
      check("R12 released after strobe", 64'(dout_oe_o), 64'd0);
    end

    // R11 key read with wrap
    key_i = {16'($urandom), 32'($urandom)};
    read_xfer(8'h42, 7);
    for (int k = 0; k < 7; k++)
      check("R11 key byte", 64'(rdq[k]), 64'(key_i[(k % 6)*8 +: 8]));

    // random writes
    for (int r = 0; r < 14; r++)
      do_write(6'($urandom % 56), 1'($urandom), 1 + int'($urandom % 5));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule